// File: doc/BRIEF.md
# External Bus Cycle Sequencer with READY Handshake

This block runs one external bus transfer at a time, read or write. An internal requester presents an address, a direction, and per-transfer settings. The settings are a programmed wait-state count, a flag for the multiplexed address/data bus, a flag that turns on the READY handshake, and a flag that adds a turnaround state. The block then drives the active-low read or write strobe. The strobe is held for the programmed wait states. When the handshake is on, the strobe is also held for as long as the external READY line stays high.

READY is active low and asynchronous to the block clock. It passes through a two-flop synchronizer before the sequencer looks at it. The sequencer looks at it only after the programmed wait states have run out. After the strobe ends, a multiplexed transfer always takes one recovery clock. An optional turnaround clock may follow it.

A `busy` flag covers the whole transfer. A one-clock `done` pulse marks normal completion. An `abort` input returns the sequencer to idle from any state. Abort is the only way out of a handshake transfer whose READY never arrives.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While reset is asserted and directly after it, `busy` and `done` are 0 and both `rd_n` and `wr_n` are 1.
- R2: A request (`req_valid`=1) is taken only at a clock edge where `busy` is 0 and `abort` is 0. From the next cycle on, `busy` is 1 and exactly one strobe is 0: `wr_n` if `req_write`=1, `rd_n` otherwise. A request presented while `busy` is 1 has no effect.
- R3: With `req_rdy_en`=0, the strobe stays low for 1 + `req_ws` cycles, using all 4 bits of `req_ws` (0..15), whatever the level of `ready_n`.
- R4: With `req_rdy_en`=1, only `req_ws[2:0]` counts (0..7). Bit 3 is ignored.
- R5: With `req_rdy_en`=1, once the programmed wait states have elapsed, each clock edge where the synchronized READY is 1 adds one strobe cycle. The edge where it is 0 ends the strobe.
- R6: The level of `ready_n` taken at clock edge k is the one the sequencer acts on at edge k+2 (two-flop synchronizer, reset value 1).
- R7: With `req_mux`=1, one recovery cycle follows the strobe. In that cycle `busy` is 1 and both strobes are 1.
- R8: With `req_turn`=1, one more such cycle follows. The post-strobe delay is therefore 2 cycles for multiplexed with turnaround, 1 cycle for either flag alone, and 0 cycles for neither.
- R9: A handshake transfer whose synchronized READY never reads 0 keeps `busy` at 1 and its strobe at 0 indefinitely.
- R10: `abort`=1 at a clock edge makes `busy` 0 and both strobes 1 from the next cycle, and produces no `done` pulse.
- R11: `done` is 1 for exactly the first cycle in which `busy` is 0 after a transfer that completed without abort. Otherwise it is 0.
- R12: `bus_addr` shows the accepted `req_addr` from the cycle `busy` rises and holds it until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Forces return to idle |
| req_valid | input | 1 | Request strobe from the internal side |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mux | input | 1 | Multiplexed address/data bus transfer |
| req_ws | input | WS_W | Programmed wait-state count |
| req_rdy_en | input | 1 | Enables the READY handshake |
| req_turn | input | 1 | Adds a turnaround state |
| ready_n | input | 1 | Asynchronous active-low READY from the bus |
| bus_addr | output | ADDR_W | Latched address of the current transfer |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Transfers without the handshake are run at wait counts 0 and 15 with READY held high. This separates the full 4-bit count from the truncated one and shows that READY is ignored. Handshake transfers use a count with bit 3 set, first with READY already low and then with READY released several clocks late. The first case exposes the 3-bit cut. The second measures the synchronizer latency and the extra READY wait states against a behavioural model. All four mux/turnaround combinations separate the 0-, 1- and 2-cycle recovery tails. A READY that never arrives, followed by abort, and requests issued mid-transfer confirm the stall, the release and the rejection of overlapping requests.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // Width of the wait-state field that survives when READY control is on.
    localparam int RDY_WS_W    = 3;
    // Flops in the READY synchronizer chain.
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_MUXR = 2'd2,
        ST_TURN = 2'd3
    } xbus_st_e;
endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], async_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign sync_n = stg_q[LAST];

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_n == $past(async_n, 2)));
endmodule

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3
    ctr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !zero);
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_mux,
    input  logic [WS_W-1:0]   req_ws,
    input  logic              req_rdy_en,
    input  logic              req_turn,
    input  logic              ready_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic              busy,
    output logic              done
);
    localparam int PAD_W = WS_W - RDY_WS_W;

    typedef struct packed {
        xbus_st_e          st;
        logic              write;
        logic              mux;
        logic              turn;
        logic              rdy_en;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    seq_t seq_q;
    seq_t seq_d;

    logic            rdy_s_n;
    logic            ctr_zero;
    logic            ctr_load;
    logic            ctr_dec;
    logic [WS_W-1:0] eff_ws;

    xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (ready_n),
        .sync_n  (rdy_s_n)
    );

    xbus_wait_ctr #(.W(WS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (eff_ws),
        .dec      (ctr_dec),
        .zero     (ctr_zero)
    );

    // Truncate the wait field when the READY handshake takes over the cycle end.
    always_comb begin
        if (req_rdy_en) eff_ws = {{PAD_W{1'b0}}, req_ws[RDY_WS_W-1:0]};
        else            eff_ws = req_ws;
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ctr_load   = 1'b0;
        ctr_dec    = 1'b0;
        if (abort) begin
            seq_d.st = ST_IDLE;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (req_valid) begin
                        seq_d.st     = ST_CMD;
                        seq_d.write  = req_write;
                        seq_d.mux    = req_mux;
                        seq_d.turn   = req_turn;
                        seq_d.rdy_en = req_rdy_en;
                        seq_d.addr   = req_addr;
                        ctr_load     = 1'b1;
                    end
                end
                ST_CMD: begin
                    if (!ctr_zero) begin
                        ctr_dec = 1'b1;
                    end else if (seq_q.rdy_en && rdy_s_n) begin
                        seq_d.st = ST_CMD;
                    end else if (seq_q.mux) begin
                        seq_d.st = ST_MUXR;
                    end else if (seq_q.turn) begin
                        seq_d.st = ST_TURN;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
                ST_MUXR: begin
                    if (seq_q.turn) begin
                        seq_d.st = ST_TURN;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
                ST_TURN: begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= ST_IDLE;
        end else begin
            seq_q        <= seq_d;
        end
    end

    assign busy     = (seq_q.st != ST_IDLE);
    assign rd_n     = !((seq_q.st == ST_CMD) && !seq_q.write);
    assign wr_n     = !((seq_q.st == ST_CMD) &&  seq_q.write);
    assign bus_addr = seq_q.addr;
    assign done     = seq_q.done;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n));
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !abort) |=> (busy && (rd_n != wr_n)));
    // R5
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_CMD) && ctr_zero && seq_q.rdy_en && rdy_s_n && !abort)
        |=> (seq_q.st == ST_CMD));
    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && rd_n && wr_n && !done));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(bus_addr));
endmodule

// File: tb/sim_xbus_cycle_seq.sv
`timescale 1ns/1ps
module sim_xbus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_mux = 1'b0;
    logic [3:0]  req_ws = '0;
    logic        req_rdy_en = 1'b0;
    logic        req_turn = 1'b0;
    logic        ready_n = 1'b1;
    logic [15:0] bus_addr;
    logic        rd_n, wr_n, busy, done;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    xbus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .abort(abort), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_mux(req_mux),
        .req_ws(req_ws), .req_rdy_en(req_rdy_en), .req_turn(req_turn),
        .ready_n(ready_n), .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n),
        .busy(busy), .done(done)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 strobe, 2 post-strobe tail.
    int          m_ph = 0;
    int          m_wl = 0;
    int          m_post = 0;
    bit          m_wr = 0;
    bit          m_ren = 0;
    bit          m_done = 0;
    bit          m_s1 = 1;
    bit          m_s2 = 1;
    logic [15:0] m_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_done = 0; m_addr = '0; m_wr = 0; m_ren = 0;
            m_s1 = 1; m_s2 = 1;
        end else begin
            bit smp;
            smp  = m_s2;
            m_s2 = m_s1;
            m_s1 = ready_n;
            m_done = 0;
            if (abort) begin
                m_ph = 0;
            end else if (m_ph == 0) begin
                if (req_valid) begin
                    m_ph   = 1;
                    m_wr   = req_write;
                    m_ren  = req_rdy_en;
                    m_addr = req_addr;
                    m_wl   = req_rdy_en ? int'(req_ws & 4'd7) : int'(req_ws);
                    m_post = int'(req_mux) + int'(req_turn);
                end
            end else if (m_ph == 1) begin
                if (m_wl > 0) m_wl--;
                else if (!(m_ren && smp)) begin
                    if (m_post > 0) m_ph = 2;
                    else begin m_ph = 0; m_done = 1; end
                end
            end else begin
                m_post--;
                if (m_post == 0) begin m_ph = 0; m_done = 1; end
            end
        end
        #3;
        cmp(cur_req, "busy", busy, (m_ph != 0));
        cmp(cur_req, "rd_n", rd_n, !(m_ph == 1 && !m_wr));
        cmp(cur_req, "wr_n", wr_n, !(m_ph == 1 && m_wr));
        cmp(cur_req, "done", done, m_done);
        cmp(cur_req, "bus_addr", bus_addr, m_addr);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_req(input bit wr, input bit mux, input logic [3:0] ws,
                          input bit ren, input bit turn, input logic [15:0] a,
                          output int slen, output int blen);
        int guard;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_mux = mux; req_ws = ws;
        req_rdy_en = ren; req_turn = turn; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        slen = 0; blen = 0; guard = 0;
        while (busy && guard < 2000) begin
            if (!rd_n || !wr_n) slen++;
            blen++;
            // R12
            cmp("R12", "bus_addr during busy", bus_addr, a);
            guard++;
            @(negedge clk);
        end
        // R11
        cmp("R11", "done at first idle cycle", done, 1);
    endtask

    initial begin
        int sl, bl;
        repeat (3) @(negedge clk);
        // R1
        cmp("R1", "busy in reset", busy, 0);
        cmp("R1", "strobes in reset", {rd_n, wr_n}, 2'b11);
        rst_n = 1;
        @(negedge clk);
        cmp("R1", "done after reset", done, 0);

        cur_req = "R3";
        ready_n = 1;
        do_req(0, 0, 4'd0, 0, 0, 16'h1234, sl, bl);
        cmp("R3", "strobe len ws=0", sl, 1);
        do_req(1, 0, 4'd15, 0, 0, 16'hBEEF, sl, bl);
        cmp("R3", "strobe len ws=15", sl, 16);

        cur_req = "R4";
        ready_n = 0;
        repeat (3) @(negedge clk);
        do_req(0, 0, 4'd10, 1, 0, 16'h0F0F, sl, bl);
        cmp("R4", "strobe len ws=10 rdy", sl, 3);
        do_req(1, 0, 4'd7, 1, 0, 16'h7777, sl, bl);
        cmp("R4", "strobe len ws=7 rdy", sl, 8);

        cur_req = "R8";
        do_req(0, 1, 4'd2, 0, 1, 16'hA001, sl, bl);
        cmp("R8", "tail mux+turn", bl - sl, 2);
        cur_req = "R7";
        do_req(1, 1, 4'd2, 0, 0, 16'hA002, sl, bl);
        cmp("R7", "tail mux", bl - sl, 1);
        cur_req = "R8";
        do_req(0, 0, 4'd2, 0, 1, 16'hA003, sl, bl);
        cmp("R8", "tail turn", bl - sl, 1);
        do_req(1, 0, 4'd2, 0, 0, 16'hA004, sl, bl);
        cmp("R8", "tail none", bl - sl, 0);

        cur_req = "R5";
        ready_n = 1;
        repeat (3) @(negedge clk);
        fork
            do_req(0, 0, 4'd2, 1, 0, 16'h5A5A, sl, bl);
            begin
                repeat (9) @(negedge clk);
                ready_n = 0;
            end
        join
        cmp("R5", "strobe stretched by READY", (sl > 3), 1);
        cur_req = "R6";
        ready_n = 1;
        repeat (3) @(negedge clk);
        fork
            do_req(1, 1, 4'd0, 1, 1, 16'h6666, sl, bl);
            begin
                repeat (2) @(negedge clk);
                ready_n = 0;
                @(negedge clk);
                ready_n = 1;
            end
        join

        cur_req = "R2";
        ready_n = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_mux = 0; req_ws = 4'd6;
        req_rdy_en = 0; req_turn = 0; req_addr = 16'h2222;
        @(negedge clk);
        req_addr = 16'h3333; req_write = 1;
        repeat (3) @(negedge clk);
        cmp("R2", "request ignored while busy", bus_addr, 16'h2222);
        cmp("R2", "strobe kept", {rd_n, wr_n}, 2'b01);
        req_valid = 0;
        repeat (6) @(negedge clk);
        cmp("R2", "idle after ignored request", busy, 0);

        cur_req = "R9";
        ready_n = 1;
        repeat (3) @(negedge clk);
        req_valid = 1; req_write = 1; req_ws = 4'd1; req_rdy_en = 1;
        req_addr = 16'h9999;
        @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
        cmp("R9", "still busy", busy, 1);
        cmp("R9", "write strobe held", wr_n, 0);
        cur_req = "R10";
        abort = 1;
        @(negedge clk);
        abort = 0;
        cmp("R10", "busy after abort", busy, 0);
        cmp("R10", "strobes after abort", {rd_n, wr_n}, 2'b11);
        cmp("R10", "no done after abort", done, 0);
        @(negedge clk);
        cmp("R10", "no done later", done, 0);

        cur_req = "R11";
        ready_n = 0;
        do_req(0, 1, 4'd3, 0, 1, 16'hD0D0, sl, bl);
        @(negedge clk);
        cmp("R11", "done one cycle only", done, 0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule